// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between an SDRAM command issuer and the command bus of a single-bank SDRAM. Each request arrives with a valid/ready handshake. The guard withholds ready until every minimum spacing that applies to the requested command has elapsed since the earlier command that started it. Five spacings are held in a programmable configuration register. Each spacing is loaded into its own down-counter when the command that opens the interval is issued.

An optional decode cycle can be switched on with a level input. When it is on, any request marked as non-sequential is held for one extra cycle after all its spacings have cleared. Sequential requests are never delayed by it.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A synchronous reset clears every running interval, loads the default delays (row-to-column 2, activate-to-precharge 5, precharge 3, refresh-to-activate 7, self-refresh-exit 8) and leaves busy low. The first request after reset is therefore accepted in the cycle it is presented.
- R2: The command codes are activate 0, read 1, write 2, precharge 3, refresh 4 and self-refresh exit 5; codes 6 and 7 are other commands. Issue is high exactly when req_valid and req_ready are both high. While issue is high, issue_cmd equals req_cmd; otherwise it is 0.
- R3: A read or write is not issued until at least trcd+1 cycles after the last activate.
- R4: A precharge is not issued until at least tras+1 cycles after the last activate.
- R5: No command of any code is issued until at least trp+1 cycles after the last precharge.
- R6: An activate is not issued until at least trc+1 cycles after the last refresh.
- R7: An activate is not issued until at least txsr+1 cycles after the last self-refresh exit.
- R8: A delay field programmed to 0 imposes no wait, so the dependent command may issue in the next cycle.
- R9: When several intervals block one request, ready stays low until the longest of them has expired. Ready is low during the stall whether or not req_valid is high.
- R10: When cfg_we is high, cfg_wdata is loaded at the clock edge. Its layout is trcd [3:0], tras [7:4], trp [11:8], trc [15:12], txsr [19:16]. A field is sampled when its interval starts, so a write does not change a countdown that is already running.
- R11: While dec_en is high, a request with req_nonseq high is held for one cycle after all of its intervals have cleared. While dec_en is low, or for a sequential request, no cycle is added.
- R12: busy is high in every cycle in which at least one interval is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Requested command code |
| req_nonseq | input | 1 | Request starts a non-sequential access |
| req_ready | output | 1 | Request may issue this cycle |
| cfg_we | input | 1 | Load the delay register |
| cfg_wdata | input | 20 | New delay fields |
| dec_en | input | 1 | Decode cycle enable |
| issue | output | 1 | Command issued this cycle |
| issue_cmd | output | 3 | Issued command code |
| busy | output | 1 | Some interval still running |

## Verification
On every cycle, the assertions check each of the five spacings against cycle counters that the checker keeps itself. They also check the handshake, the rule that a non-sequential request is held in its first cycle, busy after a precharge with a nonzero delay, and the reset state. The bench scenarios are needed for several behaviours: exact stall lengths, which interval wins when two overlap, and that a configuration write leaves a running countdown alone. These depend on the order of commands and writes, which only a reference model can follow.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int DW = 4,
  parameter int CW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CW-1:0]     req_cmd,
  input  logic              req_nonseq,
  output logic              req_ready,
  input  logic              cfg_we,
  input  logic [5*DW-1:0]   cfg_wdata,
  input  logic              dec_en,
  output logic              issue,
  output logic [CW-1:0]     issue_cmd,
  output logic              busy
);
  localparam int NT   = 5;
  localparam int CFGW = NT * DW;
  localparam int T_RCD = 0, T_RAS = 1, T_RP = 2, T_RC = 3, T_XSR = 4;
  localparam logic [CW-1:0] C_ACT = CW'(0), C_RD = CW'(1), C_WR = CW'(2),
                            C_PRE = CW'(3), C_REF = CW'(4), C_SRX = CW'(5);
  localparam logic [NT*CW-1:0] SRC = {C_SRX, C_REF, C_PRE, C_ACT, C_ACT};
  localparam logic [CFGW-1:0] CFG_RST = {DW'(8), DW'(7), DW'(3), DW'(5), DW'(2)};

  logic [CFGW-1:0] cfg_q;
  logic [NT-1:0]   run, block;
  logic            dc_seen, clear, need_dc;

  always_ff @(posedge clk)
    if (rst)         cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic [DW-1:0] cnt;
    logic          load;
    assign load   = issue && (req_cmd == SRC[i*CW +: CW]);
    assign run[i] = (cnt != '0);
    always_ff @(posedge clk)
      if (rst)         cnt <= '0;
      else if (load)   cnt <= cfg_q[i*DW +: DW];
      else if (run[i]) cnt <= cnt - DW'(1);
  end

  always_comb begin
    block = '0;
    block[T_RP] = 1'b1;
    case (req_cmd)
      C_ACT:      begin block[T_RC] = 1'b1; block[T_XSR] = 1'b1; end
      C_RD, C_WR: block[T_RCD] = 1'b1;
      C_PRE:      block[T_RAS] = 1'b1;
      default:    ;
    endcase
  end

  assign clear     = (run & block) == '0;
  assign need_dc   = dec_en && req_nonseq && !dc_seen;
  assign req_ready = clear && !need_dc;
  assign issue     = req_valid && req_ready;
  assign issue_cmd = issue ? req_cmd : '0;
  assign busy      = |run;

  always_ff @(posedge clk)
    if (rst) dc_seen <= 1'b0;
    else     dc_seen <= req_valid && clear && !issue;
endmodule

// File: rtl/guard_rules.sv
module guard_rules #(
  parameter int DW = 4,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [CW-1:0]   req_cmd,
  input logic            req_nonseq,
  input logic            req_ready,
  input logic            dec_en,
  input logic            issue,
  input logic [CW-1:0]   issue_cmd,
  input logic            busy,
  input logic [5*DW-1:0] cfg_q
);
  logic [4:0]    since [5];
  logic [DW-1:0] lat   [5];
  logic [CW-1:0] src   [5];
  assign src[0] = CW'(0);
  assign src[1] = CW'(0);
  assign src[2] = CW'(3);
  assign src[3] = CW'(4);
  assign src[4] = CW'(5);

  always_ff @(posedge clk)
    for (int i = 0; i < 5; i++)
      if (rst) begin
        since[i] <= 5'd31;
        lat[i]   <= '0;
      end else if (issue && issue_cmd == src[i]) begin
        since[i] <= 5'd1;
        lat[i]   <= cfg_q[i*DW +: DW];
      end else if (since[i] != 5'd31) begin
        since[i] <= since[i] + 5'd1;
      end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !busy);
  a_r2_handshake: assert property (@(posedge clk) disable iff (rst)
    issue |-> (req_valid && req_ready && issue_cmd == req_cmd));
  a_r3_rcd: assert property (@(posedge clk) disable iff (rst)
    (issue && (issue_cmd == CW'(1) || issue_cmd == CW'(2))) |-> (since[0] > 5'(lat[0])));
  a_r4_ras: assert property (@(posedge clk) disable iff (rst)
    (issue && issue_cmd == CW'(3)) |-> (since[1] > 5'(lat[1])));
  a_r5_rp: assert property (@(posedge clk) disable iff (rst)
    issue |-> (since[2] > 5'(lat[2])));
  a_r6_rc: assert property (@(posedge clk) disable iff (rst)
    (issue && issue_cmd == CW'(0)) |-> (since[3] > 5'(lat[3])));
  a_r7_xsr: assert property (@(posedge clk) disable iff (rst)
    (issue && issue_cmd == CW'(0)) |-> (since[4] > 5'(lat[4])));
  a_r11_decode: assert property (@(posedge clk) disable iff (rst)
    (dec_en && req_nonseq && req_valid && !$past(req_valid)) |-> !req_ready);
  a_r12_busy_pre: assert property (@(posedge clk) disable iff (rst)
    (issue && issue_cmd == CW'(3) && cfg_q[2*DW +: DW] != '0) |=> busy);
endmodule

bind sdram_cmd_guard guard_rules #(.DW(DW), .CW(CW)) u_rules (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_nonseq(req_nonseq), .req_ready(req_ready), .dec_en(dec_en),
  .issue(issue), .issue_cmd(issue_cmd), .busy(busy), .cfg_q(cfg_q)
);

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
  localparam int CLK_P = 10;
  localparam logic [19:0] DEF = 20'h87352;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_nonseq = 0, cfg_we = 0, dec_en = 0;
  logic [2:0] req_cmd = 0;
  logic [19:0] cfg_wdata = 0;
  logic req_ready, issue, busy;
  logic [2:0] issue_cmd;

  sdram_cmd_guard u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_nonseq(req_nonseq), .req_ready(req_ready), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dec_en(dec_en), .issue(issue), .issue_cmd(issue_cmd), .busy(busy));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int allow [5];
  logic [19:0] mcfg = DEF;
  bit mdc = 0, obs_issue = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit m_clear(logic [2:0] c);
    bit [4:0] b;
    b = 5'b00100;
    case (c)
      3'd0: b |= 5'b11000;
      3'd1, 3'd2: b |= 5'b00001;
      3'd3: b |= 5'b00010;
      default: ;
    endcase
    for (int i = 0; i < 5; i++) if (b[i] && cyc < allow[i]) return 0;
    return 1;
  endfunction

  function automatic int src_of(int i);
    case (i) 0, 1: return 0; 2: return 3; 3: return 4; default: return 5; endcase
  endfunction

  task automatic step();
    bit cl, er, eb, ei;
    #1;
    cl = m_clear(req_cmd);
    er = cl && !(dec_en && req_nonseq && !mdc);
    ei = req_valid && er;
    eb = 0;
    for (int i = 0; i < 5; i++) if (cyc < allow[i]) eb = 1;
    if (!rst) begin
      chk(req_ready == er, (cl ? "R11" : (req_cmd == 0 ? "R6" : (req_cmd == 3 ? "R4" :
          (req_cmd == 1 || req_cmd == 2 ? "R3" : "R5")))), int'(req_ready), int'(er));
      chk(issue == ei && issue_cmd == (ei ? req_cmd : 3'd0), "R2", int'({issue, issue_cmd}),
          int'({ei, ei ? req_cmd : 3'd0}));
      chk(busy == eb, "R12", int'(busy), int'(eb));
    end
    obs_issue = issue;
    @(posedge clk);
    if (rst) begin
      foreach (allow[i]) allow[i] = 0;
      mcfg = DEF;
      mdc = 0;
    end else begin
      if (ei) for (int i = 0; i < 5; i++)
        if (src_of(i) == int'(req_cmd)) allow[i] = cyc + int'(mcfg[i*4 +: 4]) + 1;
      mdc = req_valid && cl && !ei;
      if (cfg_we) mcfg = cfg_wdata;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic cfg(logic [19:0] v);
    cfg_we = 1; cfg_wdata = v;
    step();
    cfg_we = 0;
  endtask

  task automatic send(logic [2:0] c, bit ns, int exp, string tag);
    int stall = 0;
    req_valid = 1; req_cmd = c; req_nonseq = ns;
    forever begin
      step();
      if (obs_issue || stall > 60) break;
      stall++;
    end
    req_valid = 0; req_nonseq = 0;
    chk(stall == exp, tag, stall, exp);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    @(negedge clk);
    idle(3);
    rst = 0;
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    send(3'd0, 0, 0, "R1 first act");
    send(3'd1, 0, 2, "R3 read after act");
    send(3'd3, 0, 2, "R4 pre after act");
    send(3'd4, 0, 3, "R5 ref after pre");
    send(3'd0, 0, 7, "R6 act after ref");
    idle(20);
    send(3'd5, 0, 0, "R2 srx");
    send(3'd0, 0, 8, "R7 act after srx");
    idle(20);
    send(3'd3, 0, 0, "R12 pre");
    req_cmd = 3'd0;
    step(); step(); step();
    chk(busy == 0 && req_ready == 1, "R12 busy drop", int'({busy, req_ready}), 1);
    idle(20);
    cfg(20'h2C352);
    send(3'd4, 0, 0, "R9 ref");
    send(3'd5, 0, 0, "R9 srx");
    send(3'd0, 0, 11, "R9 longest");
    idle(20);
    cfg(20'h87356);
    send(3'd0, 0, 0, "R10 act");
    cfg(20'h87351);
    send(3'd1, 0, 5, "R10 running count kept");
    idle(20);
    send(3'd0, 0, 0, "R10 act2");
    send(3'd2, 0, 1, "R10 new trcd");
    idle(20);
    cfg(20'h00000);
    send(3'd0, 0, 0, "R8 act");
    send(3'd1, 0, 0, "R8 read");
    send(3'd3, 0, 0, "R8 pre");
    send(3'd4, 0, 0, "R8 ref");
    send(3'd0, 0, 0, "R8 act after ref");
    idle(5);
    cfg(DEF);
    dec_en = 1;
    idle(20);
    send(3'd0, 1, 1, "R11 nonseq act");
    send(3'd1, 0, 2, "R11 seq read");
    send(3'd3, 1, 3, "R11 nonseq pre");
    idle(20);
    dec_en = 0;
    send(3'd0, 1, 0, "R11 disabled");
    idle(10);
    rst = 1;
    idle(2);
    rst = 0;
    chk(busy == 0, "R1 second reset", int'(busy), 0);
    send(3'd7, 0, 0, "R2 other code");
    finish_up();
  end
endmodule